// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Status Queue

This block takes an asynchronous serial line and turns it into a stream of characters for a host. The line is sampled sixteen times per bit. A shared enable tick sets the sample rate, so baud generation stays outside the block. Each recovered character is checked for parity and for a valid stop bit, and a line held low through a whole character is recognised as a break. Every character, together with its own error flags, goes into a sixteen-deep receive queue. The host pops the queue with a read strobe.

One character can wait in a holding register behind a full queue. When a further character completes while that register is still occupied, a sticky overrun flag is raised. The host sees a ready flag, a full flag and the overrun flag. It can issue two commands with a strobe and a five-bit code: one restarts the receiver and the other clears the error status. A one-cycle break-change pulse marks both the start and the end of a break.

Top module: `uart_rx_stfifo`

## Requirements
- R1: A frame is one low start bit, then `cfg_len`+5 data bits sent LSB first, then an optional parity bit and a stop bit. Each bit is sampled near its middle on the 16x tick. The character appears on `rd_data` right-aligned, and the bits above the programmed length read as zero.
- R2: A start bit that is high again at its mid-bit sample is rejected, and the receiver returns to idle without storing anything.
- R3: `cfg_par` selects the parity mode: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 forced (the parity bit must be 1). A mismatch sets `rd_pe` for that character's entry only.
- R4: A low sample at the middle of the stop bit sets `rd_fe` for that character.
- R5: A break is a frame whose data bits, parity bit (if any) and stop bit all sample low. It is stored as a single entry with `rd_brk`=1, `rd_fe`=1 and data 0. After a break, nothing more is stored until `rxd` has been high for 8 consecutive ticks. A break that starts partway through a character produces that character with a framing error, followed by the break entry, provided the line stays low through the next whole character.
- R6: `brk_chg` is high for exactly one cycle when a break is detected, and again when the break ends.
- R7: The queue returns characters in arrival order. `st_rxrdy` is 1 whenever the queue holds an entry and drops only after a read that empties it. A read strobe on an empty queue has no effect.
- R8: `st_rxfull` is 1 when all 16 entries are occupied and clears on a read that frees a slot. If a character is waiting in the holding register, it enters the queue in the same cycle as the read, so `st_rxfull` stays 1 until the second read.
- R9: `st_ovr` sets when a character completes while the queue is full and another character is already waiting. The waiting character is replaced by the new one, and the flag stays set until it is cleared by command.
- R10: With `cmd_stb`, `cmd_code` 5'b00010 empties the queue, drops the waiting character, ends any break and returns the receiver to idle. 5'b00100 clears `st_ovr`. 5'b00000 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial input, idles high |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_par | input | 2 | Parity mode |
| rd_stb | input | 1 | Pops the head entry |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| rd_data | output | 8 | Head entry character |
| rd_pe | output | 1 | Head entry parity error |
| rd_fe | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| st_rxrdy | output | 1 | Queue not empty |
| st_rxfull | output | 1 | Queue full |
| st_ovr | output | 1 | Sticky overrun |
| brk_chg | output | 1 | Break start or end pulse |

## Verification
The assertions check the following on every cycle:
- the full flag never appears without the ready flag;
- the full flag holds across a read while a character is waiting;
- the ready flag falls only after a read or a receiver reset;
- the overrun flag stays set until it is cleared by command;
- no frame completes while a break is still active;
- the break-change output is always a single-cycle pulse.

Other behaviour depends on whole serial frames and needs the bench's scenarios. These cover:
- recovered character values under every combination of length and parity mode;
- the per-entry flags;
- the break entry and its release;
- which character survives an overrun;
- rejection of a false start.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } urx_entry_t;

  localparam logic [4:0] CMD_NOP     = 5'b00000;
  localparam logic [4:0] CMD_RST_RX  = 5'b00010;
  localparam logic [4:0] CMD_CLR_ERR = 5'b00100;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRKW
  } urx_state_e;
endpackage

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       flush,
  output logic       done,
  output urx_entry_t ent,
  output logic       brk_active,
  output logic       brk_chg
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OSR / 2;

  urx_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [DW-1:0]   sh_q, sh_d;
  logic            pb_q, pb_d;
  logic            chg_q, chg_d;
  logic [IW:0]     nbits;
  logic [DW-1:0]   dal;
  logic            par_on, exp_pb, is_brk;

  assign nbits  = (IW+1)'(cfg_len) + (IW+1)'(5);
  assign par_on = (cfg_par != 2'b00);
  assign dal    = sh_q >> ((IW+1)'(DW) - nbits);

  always_comb begin
    case (cfg_par)
      2'b01:   exp_pb = ^dal;
      2'b10:   exp_pb = ~^dal;
      default: exp_pb = 1'b1;
    endcase
  end

  assign is_brk = (dal == '0) && !(par_on && pb_q) && !rxd_s;

  always_comb begin
    ent.data = dal;
    ent.pe   = par_on && (pb_q != exp_pb) && !is_brk;
    ent.fe   = !rxd_s;
    ent.brk  = is_brk;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    pb_d  = pb_q;
    chg_d = 1'b0;
    done  = 1'b0;
    if (flush) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            idx_d = '0;
            sh_d  = '0;
            st_d  = rxd_s ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            sh_d  = {rxd_s, sh_q[DW-1:1]};
            idx_d = idx_q + 1'b1;
            if ({1'b0, idx_q} == nbits - 1'b1)
              st_d = par_on ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            pb_d  = rxd_s;
            st_d  = RX_STOP;
          end
        end
        RX_STOP: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            done  = 1'b1;
            st_d  = RX_IDLE;
            if (is_brk) begin
              st_d  = RX_BRKW;
              chg_d = 1'b1;
            end
          end
        end
        RX_BRKW: begin
          cnt_d = rxd_s ? cnt_q + 1'b1 : '0;
          if (rxd_s && cnt_q == CW'(HALF - 1)) begin
            cnt_d = '0;
            st_d  = RX_IDLE;
            chg_d = 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
    if (!par_on && st_q == RX_DATA) pb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
      chg_q <= chg_d;
    end
  end

  assign brk_active = (st_q == RX_BRKW);
  assign brk_chg    = chg_q;
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           push,
  input  logic           pop,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = wp_q + 1'b1;
      if (pop)  rp_d = rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_rx_stfifo.sv
module uart_rx_stfifo
  import urx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       rd_stb,
  input  logic       cmd_stb,
  input  logic [4:0] cmd_code,
  output logic [7:0] rd_data,
  output logic       rd_pe,
  output logic       rd_fe,
  output logic       rd_brk,
  output logic       st_rxrdy,
  output logic       st_rxfull,
  output logic       st_ovr,
  output logic       brk_chg
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = $bits(urx_entry_t);

  logic [1:0]  sync_q;
  logic        rxd_s;
  logic        rst_rx, clr_err;
  logic        rx_done, brk_act;
  urx_entry_t  rx_ent, hold_q, hold_d, head;
  logic        hold_v, hold_v_d;
  logic        ovr_q, ovr_d;
  logic        push, pop, full;
  logic [AW:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rxd_s = sync_q[1];

  assign rst_rx  = cmd_stb && (cmd_code == CMD_RST_RX);
  assign clr_err = cmd_stb && (cmd_code == CMD_CLR_ERR);

  urx_frame #(.OSR(OSR), .DW(8)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rxd_s      (rxd_s),
    .cfg_len    (cfg_len),
    .cfg_par    (cfg_par),
    .flush      (rst_rx),
    .done       (rx_done),
    .ent        (rx_ent),
    .brk_active (brk_act),
    .brk_chg    (brk_chg)
  );

  assign full = (count == (AW+1)'(DEPTH));
  assign pop  = rd_stb && (count != '0) && !rst_rx;
  assign push = hold_v && (!full || pop) && !rst_rx;

  always_comb begin
    hold_d   = hold_q;
    hold_v_d = hold_v;
    ovr_d    = ovr_q;
    if (rst_rx) begin
      hold_v_d = 1'b0;
    end else if (rx_done) begin
      hold_d   = rx_ent;
      hold_v_d = 1'b1;
      if (hold_v && !push) ovr_d = 1'b1;
    end else if (push) begin
      hold_v_d = 1'b0;
    end
    if (clr_err) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      hold_v <= hold_v_d;
      ovr_q  <= ovr_d;
    end
  end

  urx_fifo #(.DEPTH(DEPTH), .W(EW)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (rst_rx),
    .push  (push),
    .pop   (pop),
    .din   (hold_q),
    .dout  (head),
    .count (count)
  );

  assign rd_data   = head.data;
  assign rd_pe     = head.pe;
  assign rd_fe     = head.fe;
  assign rd_brk    = head.brk;
  assign st_rxrdy  = (count != '0);
  assign st_rxfull = full;
  assign st_ovr    = ovr_q;
endmodule

// File: rtl/urx_chk.sv
module urx_chk
  import urx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       cmd_stb,
  input logic [4:0] cmd_code,
  input logic       st_rxrdy,
  input logic       st_rxfull,
  input logic       st_ovr,
  input logic       brk_chg,
  input logic       brk_active,
  input logic       frame_done,
  input logic       hold_v
);
  logic rstc, clrc;
  assign rstc = cmd_stb && (cmd_code == CMD_RST_RX);
  assign clrc = cmd_stb && (cmd_code == CMD_CLR_ERR);

  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    st_rxfull |-> st_rxrdy); // R8
  AST_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    st_rxfull && !rd_stb && !rstc |=> st_rxfull); // R8
  AST_FULL_WAITER_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
    st_rxfull && hold_v && rd_stb && !rstc |=> st_rxfull); // R8
  AST_RDY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_rxrdy) |-> ($past(rd_stb) || $past(rstc))); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovr && !clrc |=> st_ovr); // R9
  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clrc |=> !st_ovr); // R10
  AST_NO_FRAME_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> !frame_done); // R5
  AST_BRKCHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_chg |=> !brk_chg); // R6
endmodule

bind uart_rx_stfifo urx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_stb     (rd_stb),
  .cmd_stb    (cmd_stb),
  .cmd_code   (cmd_code),
  .st_rxrdy   (st_rxrdy),
  .st_rxfull  (st_rxfull),
  .st_ovr     (st_ovr),
  .brk_chg    (brk_chg),
  .brk_active (brk_act),
  .frame_done (rx_done),
  .hold_v     (hold_v)
);

// File: tb/uart_rx_stfifo_tb.sv
module uart_rx_stfifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 2;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
  logic rd_stb = 1'b0, cmd_stb = 1'b0;
  logic [4:0] cmd_code = 5'd0;
  logic [7:0] rd_data;
  logic rd_pe, rd_fe, rd_brk, st_rxrdy, st_rxfull, st_ovr, brk_chg;

  int n_run = 0, n_fail = 0, n_chg = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv_c = 0;
  always @(posedge clk) begin
    tdiv_c <= (tdiv_c == TDIV-1) ? 0 : tdiv_c + 1;
    tick16 <= (tdiv_c == TDIV-1);
    if (rst_n && brk_chg) n_chg <= n_chg + 1;
  end

  uart_rx_stfifo u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .rd_stb(rd_stb),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .rd_data(rd_data),
    .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_brk(rd_brk), .st_rxrdy(st_rxrdy),
    .st_rxfull(st_rxfull), .st_ovr(st_ovr), .brk_chg(brk_chg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic line(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  // stop_mode 0: normal high stop; 1: low for 12 ticks then high
  task automatic send(input logic [7:0] d, input int len, input int pm,
                      input bit bad_par, input int stop_mode);
    logic [7:0] m;
    logic pb;
    m = 8'((1 << len) - 1) & d;
    case (pm)
      1: pb = ^m;
      2: pb = ~^m;
      default: pb = 1'b1;
    endcase
    if (bad_par) pb = ~pb;
    line(1'b0, BITC);
    for (int i = 0; i < len; i++) line(d[i], BITC);
    if (pm != 0) line(pb, BITC);
    if (stop_mode == 1) begin
      line(1'b0, 12 * TDIV);
      line(1'b1, BITC + 4 * TDIV);
    end else line(1'b1, BITC);
    line(1'b1, BITC);
  endtask

  task automatic rd_check(input string tag, input int d, input int pe,
                          input int fe, input int brk);
    chk({tag, " data"}, int'(rd_data), d);
    chk({tag, " pe"}, int'(rd_pe), pe);
    chk({tag, " fe"}, int'(rd_fe), fe);
    chk({tag, " brk"}, int'(rd_brk), brk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop1;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [4:0] c);
    cmd_code = c;
    cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 reset rxrdy", int'(st_rxrdy), 0);
    chk("R8 reset rxfull", int'(st_rxfull), 0);
    chk("R9 reset ovr", int'(st_ovr), 0);
    chk("R6 reset brk_chg", int'(brk_chg), 0);

    // R1 R3 R4 sweep over length and parity mode
    for (int l = 5; l <= 8; l++) begin
      for (int pm = 0; pm < 4; pm++) begin
        logic [7:0] msk;
        cfg_len = 2'(l - 5);
        cfg_par = 2'(pm);
        msk = 8'((1 << l) - 1);
        send(8'h5A, l, pm, 1'b0, 0);
        rd_check("R1 5A", int'(8'h5A & msk), 0, 0, 0);
        send(8'hA5, l, pm, 1'b0, 0);
        rd_check("R1 A5", int'(8'hA5 & msk), 0, 0, 0);
        send(8'hFF, l, pm, 1'b0, 0);
        rd_check("R1 FF", int'(msk), 0, 0, 0);
        if (pm != 0) begin
          send(8'h33, l, pm, 1'b1, 0);
          rd_check("R3 bad parity", int'(8'h33 & msk), 1, 0, 0);
        end
        send(8'h01, l, pm, 1'b0, 1);
        rd_check("R4 low stop", 1, 0, 1, 0);
        chk("R2 R7 empty after sweep step", int'(st_rxrdy), 0);
      end
    end

    cfg_len = 2'd3;
    cfg_par = 2'd0;

    // R2 false start
    line(1'b0, 4 * TDIV);
    line(1'b1, 3 * BITC);
    chk("R2 false start stores nothing", int'(st_rxrdy), 0);

    // R7 read of empty ignored, order
    pop1();
    send(8'h11, 8, 0, 1'b0, 0);
    send(8'h22, 8, 0, 1'b0, 0);
    chk("R7 rxrdy set", int'(st_rxrdy), 1);
    rd_check("R7 first", 8'h11, 0, 0, 0);
    chk("R7 rxrdy still set", int'(st_rxrdy), 1);
    rd_check("R7 second", 8'h22, 0, 0, 0);
    chk("R7 rxrdy cleared", int'(st_rxrdy), 0);

    // R8 full with waiting character
    for (int i = 0; i < 16; i++) send(8'(8'h40 + i), 8, 0, 1'b0, 0);
    chk("R8 full at 16", int'(st_rxfull), 1);
    send(8'h80, 8, 0, 1'b0, 0);
    chk("R8 full with waiter", int'(st_rxfull), 1);
    chk("R9 no overrun with one waiter", int'(st_ovr), 0);
    rd_check("R8 head", 8'h40, 0, 0, 0);
    chk("R8 still full after first read", int'(st_rxfull), 1);
    rd_check("R8 next", 8'h41, 0, 0, 0);
    chk("R8 released after second read", int'(st_rxfull), 0);
    for (int i = 2; i < 16; i++) rd_check("R8 drain", 8'h40 + i, 0, 0, 0);
    rd_check("R8 waiter", 8'h80, 0, 0, 0);
    chk("R7 drained", int'(st_rxrdy), 0);

    // R9 overrun
    for (int i = 0; i < 16; i++) send(8'(8'hC0 + i), 8, 0, 1'b0, 0);
    send(8'h91, 8, 0, 1'b0, 0);
    send(8'h92, 8, 0, 1'b0, 0);
    chk("R9 overrun set", int'(st_ovr), 1);
    cmd(5'b00000);
    chk("R10 nop keeps ovr", int'(st_ovr), 1);
    chk("R10 nop keeps full", int'(st_rxfull), 1);
    for (int i = 0; i < 16; i++) rd_check("R9 kept", 8'hC0 + i, 0, 0, 0);
    rd_check("R9 newest replaces waiter", 8'h92, 0, 0, 0);
    chk("R9 queue empty", int'(st_rxrdy), 0);
    chk("R9 ovr sticky", int'(st_ovr), 1);
    cmd(5'b00100);
    chk("R10 clear error", int'(st_ovr), 0);

    // R5 R6 break
    begin
      int c0;
      c0 = n_chg;
      line(1'b0, 14 * BITC);
      chk("R6 one pulse at break", n_chg - c0, 1);
      line(1'b1, BITC);
      chk("R6 pulse at break end", n_chg - c0, 2);
      rd_check("R5 break entry", 0, 0, 1, 1);
      chk("R5 single entry", int'(st_rxrdy), 0);
    end
    send(8'h6C, 8, 0, 1'b0, 0);
    rd_check("R5 receive after break", 8'h6C, 0, 0, 0);

    // R5 break starting mid character
    begin
      int c0;
      c0 = n_chg;
      line(1'b0, BITC);
      line(1'b1, 2 * BITC);
      line(1'b0, 24 * BITC);
      line(1'b1, BITC);
      chk("R6 mid break pulses", n_chg - c0, 2);
      rd_check("R5 cut character", 8'h03, 0, 1, 0);
      rd_check("R5 following break", 0, 0, 1, 1);
      chk("R5 nothing more", int'(st_rxrdy), 0);
    end

    // R10 reset receiver
    send(8'h01, 8, 0, 1'b0, 0);
    send(8'h02, 8, 0, 1'b0, 0);
    cmd(5'b00010);
    chk("R10 reset rx empties", int'(st_rxrdy), 0);
    send(8'h5E, 8, 0, 1'b0, 0);
    rd_check("R10 works after reset", 8'h5E, 0, 0, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule